// File: doc/BRIEF.md
# Register Reservation Scoreboard

This block sits beside the decode stage of an in-order pipeline and remembers which architectural registers still have a result on its way. Decode presents up to two source register indices and, for an instruction that produces a result, one destination index. The block answers with a single stall signal. While stall is high, decode holds the instruction and presents it again in a later cycle. When every source is clear, the block reserves the destination and returns a tag. The tag travels down the pipeline with the instruction. At writeback the tag comes back together with the result. The block then writes the result into its register file and drops the reservation.

All registers share one index space. General-purpose registers take the low indices and vector registers follow directly after them. Each register keeps a small count of in-flight writers rather than a single busy bit, so two outstanding writes to the same register are each tracked to completion. Register zero is never reserved. Compare-type and store-type instructions read their operands but reserve nothing. An illegal index, or a release that matches no reservation, raises an error pulse.

Top module: `reg_scoreboard`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, no register is reserved, stall is low and err is low.
- R2: stall is high in any cycle in which a valid source port names a legal register whose in-flight count is nonzero. A source whose count is zero never causes a stall.
- R3: A reservation is made only when iss_valid is high, iss_kind is 0 (result-producing), stall is low, the destination is legal and the destination is not register 0. In that case rsv_tag equals the destination index and the register's count rises by one in the next cycle. In every other case rsv_tag is -1 (all ones) and no count changes.
- R4: iss_kind 1 (compare) and iss_kind 2 (store), and the spare code 3, reserve nothing. Their sources are still checked for stalls.
- R5: A destination of register 0 is never reserved. A writeback tag of 0 or any negative tag commits nothing and raises no error.
- R6: A writeback with a positive legal tag whose register count is nonzero writes wb_data into that register and lowers its count by one, both visible from the next cycle.
- R7: Indices 0 to 15 select general registers. Indices 16 to 31 select vector register (index - 16). The two banks hold separate values.
- R8: A register reserved twice stays busy until both writebacks have arrived.
- R9: When a reservation and a release hit the same register in one cycle, the count stays unchanged. stall in that cycle reflects only the count held at the start of the cycle.
- R10: err is high in the cycle after any of these events: a valid source index of 32 or more, a result-producing issue with a destination of 32 or more, or a positive writeback tag that is illegal or names a register with a count of zero. Such a writeback changes no state.
- R11: With 3 writes already in flight to a register, a further result-producing issue to that register stalls and reserves nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_valid | input | 1 | Source A is used by the instruction in decode |
| rd_a_idx | input | 6 | Source A register index |
| rd_a_data | output | 32 | Register file value at source A (0 if illegal) |
| rd_b_valid | input | 1 | Source B is used by the instruction in decode |
| rd_b_idx | input | 6 | Source B register index |
| rd_b_data | output | 32 | Register file value at source B (0 if illegal) |
| iss_valid | input | 1 | An instruction is presented in decode |
| iss_kind | input | 2 | 0 result-producing, 1 compare, 2 store, 3 spare |
| iss_dst | input | 6 | Destination register index |
| stall | output | 1 | Hold the instruction in decode |
| rsv_tag | output | 7 | Reserved index (signed); -1 when none |
| wb_valid | input | 1 | Writeback presents a retiring instruction |
| wb_tag | input | 7 | Tag carried by the retiring instruction (signed) |
| wb_data | input | 32 | Result to commit |
| err | output | 1 | One-cycle error pulse, registered |

## Verification
The case that needs the most care is a reservation and a release of the same register in one cycle. The bench builds this on purpose: it reserves a register, and in the next cycle it issues again to that register while writeback returns that register's tag. It then checks that a read of that register still stalls, and that one further release clears it. The saturated case follows the same pattern, with a release arriving while a fourth writer waits. There the bench requires the stall to remain, because the release only takes effect in the next cycle. In the random phase, releases, issues and reads land together often, and every cycle is compared with a count-based model kept in the bench.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the register scoreboard.
package sb_pkg;
    // Instruction class as seen by the scoreboard.
    typedef enum logic [1:0] {
        KIND_WRITE   = 2'd0,
        KIND_COMPARE = 2'd1,
        KIND_STORE   = 2'd2,
        KIND_SPARE   = 2'd3
    } op_kind_e;
endpackage

// File: rtl/sb_counters.sv
`timescale 1ns/1ps
// sb_counters: one saturating-free up/down counter per register that counts
// in-flight writers. Assumes the caller never increments a full counter and
// never decrements an empty one; simultaneous inc and dec on one entry cancel.
module sb_counters #(
    parameter int NREG  = 32,
    parameter int CNT_W = 2,
    parameter int SEL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_en,
    input  logic [SEL_W-1:0] inc_sel,
    input  logic             dec_en,
    input  logic [SEL_W-1:0] dec_sel,
    output logic [NREG-1:0]  busy,
    output logic [NREG-1:0]  full
);
    for (genvar i = 0; i < NREG; i++) begin : g_ent
        logic [CNT_W-1:0] cnt_q;
        logic             inc_hit;
        logic             dec_hit;

        assign inc_hit = inc_en && (inc_sel == SEL_W'(i));
        assign dec_hit = dec_en && (dec_sel == SEL_W'(i));

        // Count update: +1 on reserve, -1 on release, unchanged when both.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                case ({inc_hit, dec_hit})
                    2'b10:   cnt_q <= cnt_q + 1'b1;
                    2'b01:   cnt_q <= cnt_q - 1'b1;
                    default: cnt_q <= cnt_q;
                endcase
            end
        end

        assign busy[i] = (cnt_q != '0);
        assign full[i] = &cnt_q;
    end
endmodule

// File: rtl/sb_regfile.sv
`timescale 1ns/1ps
// sb_regfile: general and vector register banks behind one index space.
// Low indices map to the general bank, the following ones to the vector bank.
// General register 0 is never written and always reads zero. Illegal read
// indices return zero; the caller gates writes to legal, nonzero indices.
module sb_regfile #(
    parameter int NUM_GPR = 16,
    parameter int NUM_VEC = 16,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_sel,
    input  logic [IDX_W-1:0]  rb_sel,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data
);
    localparam int NREG   = NUM_GPR + NUM_VEC;
    localparam int GSEL_W = (NUM_GPR > 1) ? $clog2(NUM_GPR) : 1;
    localparam int VSEL_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic [DATA_W-1:0] gpr_q [NUM_GPR];
    logic [DATA_W-1:0] vec_q [NUM_VEC];
    logic [IDX_W-1:0]  wvec;

    assign wvec = wsel - IDX_W'(NUM_GPR);

    // Look up one unified index in the two banks.
    function automatic logic [DATA_W-1:0] pick(input logic [IDX_W-1:0] s);
        logic [IDX_W-1:0] v;
        v = s - IDX_W'(NUM_GPR);
        if (s < IDX_W'(NUM_GPR))
            pick = gpr_q[s[GSEL_W-1:0]];
        else if (s < IDX_W'(NREG))
            pick = vec_q[v[VSEL_W-1:0]];
        else
            pick = '0;
    endfunction

    // Bank storage: clear on reset, commit one result per cycle otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int g = 0; g < NUM_GPR; g++) gpr_q[g] <= '0;
            for (int v = 0; v < NUM_VEC; v++) vec_q[v] <= '0;
        end else if (we) begin
            if (wsel != '0 && wsel < IDX_W'(NUM_GPR))
                gpr_q[wsel[GSEL_W-1:0]] <= wdata;
            else if (wsel >= IDX_W'(NUM_GPR) && wsel < IDX_W'(NREG))
                vec_q[wvec[VSEL_W-1:0]] <= wdata;
        end
    end

    // Two combinational read ports.
    always_comb begin
        ra_data = pick(ra_sel);
        rb_data = pick(rb_sel);
    end
endmodule

// File: rtl/sb_issue.sv
`timescale 1ns/1ps
// sb_issue: combinational decode-side decision. It checks both sources
// against the busy vector, refuses a destination whose count is full, and
// reserves only for a result-producing instruction with a legal nonzero
// destination once nothing stalls. Assumes busy/full reflect the current counts.
module sb_issue
    import sb_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = 6,
    parameter int SEL_W = 5
) (
    input  logic                    rd_a_valid,
    input  logic [IDX_W-1:0]        rd_a_idx,
    input  logic                    rd_b_valid,
    input  logic [IDX_W-1:0]        rd_b_idx,
    input  logic                    iss_valid,
    input  op_kind_e                iss_kind,
    input  logic [IDX_W-1:0]        iss_dst,
    input  logic [NREG-1:0]         busy,
    input  logic [NREG-1:0]         full,
    output logic                    stall,
    output logic                    rsv_en,
    output logic [SEL_W-1:0]        rsv_sel,
    output logic signed [IDX_W:0]   rsv_tag,
    output logic                    issue_err
);
    logic a_legal, b_legal, dst_legal;
    logic a_busy, b_busy;
    logic writes, dst_real, dst_full;

    // Source checks.
    always_comb begin
        a_legal = rd_a_idx < IDX_W'(NREG);
        b_legal = rd_b_idx < IDX_W'(NREG);
        a_busy  = a_legal && busy[rd_a_idx[SEL_W-1:0]];
        b_busy  = b_legal && busy[rd_b_idx[SEL_W-1:0]];
    end

    // Destination checks and the stall / reserve decision.
    always_comb begin
        writes    = iss_valid && (iss_kind == KIND_WRITE);
        dst_legal = iss_dst < IDX_W'(NREG);
        dst_real  = writes && dst_legal && (iss_dst != '0);
        dst_full  = dst_real && full[iss_dst[SEL_W-1:0]];
        stall     = (rd_a_valid && a_busy) || (rd_b_valid && b_busy) || dst_full;
        rsv_en    = dst_real && !stall;
        rsv_sel   = iss_dst[SEL_W-1:0];
        rsv_tag   = rsv_en ? $signed({1'b0, iss_dst}) : '1;
        issue_err = (rd_a_valid && !a_legal) || (rd_b_valid && !b_legal)
                  || (writes && !dst_legal);
    end
endmodule

// File: rtl/reg_scoreboard.sv
`timescale 1ns/1ps
// reg_scoreboard: register reservation scoreboard with its register file.
// Decode reads two sources and may reserve one destination per cycle;
// writeback returns a signed tag (-1 = none) plus data once per cycle.
// Assumes tags come back in any order but only for reservations that were made.
module reg_scoreboard
    import sb_pkg::*;
#(
    parameter int NUM_GPR = 16,
    parameter int NUM_VEC = 16,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 6,
    parameter int CNT_W   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_a_valid,
    input  logic [IDX_W-1:0]      rd_a_idx,
    output logic [DATA_W-1:0]     rd_a_data,
    input  logic                  rd_b_valid,
    input  logic [IDX_W-1:0]      rd_b_idx,
    output logic [DATA_W-1:0]     rd_b_data,
    input  logic                  iss_valid,
    input  logic [1:0]            iss_kind,
    input  logic [IDX_W-1:0]      iss_dst,
    output logic                  stall,
    output logic signed [IDX_W:0] rsv_tag,
    input  logic                  wb_valid,
    input  logic signed [IDX_W:0] wb_tag,
    input  logic [DATA_W-1:0]     wb_data,
    output logic                  err
);
    localparam int NREG  = NUM_GPR + NUM_VEC;
    localparam int SEL_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [NREG-1:0]  busy, full;
    logic             rsv_en, issue_err;
    logic [SEL_W-1:0] rsv_sel;
    logic [IDX_W-1:0] wb_idx;
    logic             wb_pos, wb_legal, wb_busy, wb_commit, wb_err;
    logic             err_q;
    op_kind_e         kind;

    assign kind = op_kind_e'(iss_kind);

    sb_issue #(.NREG(NREG), .IDX_W(IDX_W), .SEL_W(SEL_W)) u_issue (
        .rd_a_valid (rd_a_valid),
        .rd_a_idx   (rd_a_idx),
        .rd_b_valid (rd_b_valid),
        .rd_b_idx   (rd_b_idx),
        .iss_valid  (iss_valid),
        .iss_kind   (kind),
        .iss_dst    (iss_dst),
        .busy       (busy),
        .full       (full),
        .stall      (stall),
        .rsv_en     (rsv_en),
        .rsv_sel    (rsv_sel),
        .rsv_tag    (rsv_tag),
        .issue_err  (issue_err)
    );

    // Writeback qualification: positive tag, legal index, live reservation.
    always_comb begin
        wb_idx    = wb_tag[IDX_W-1:0];
        wb_pos    = wb_valid && !wb_tag[IDX_W] && (wb_tag != '0);
        wb_legal  = wb_idx < IDX_W'(NREG);
        wb_busy   = wb_legal && busy[wb_idx[SEL_W-1:0]];
        wb_commit = wb_pos && wb_busy;
        wb_err    = wb_pos && !wb_busy;
    end

    sb_counters #(.NREG(NREG), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (rsv_en),
        .inc_sel (rsv_sel),
        .dec_en  (wb_commit),
        .dec_sel (wb_idx[SEL_W-1:0]),
        .busy    (busy),
        .full    (full)
    );

    sb_regfile #(.NUM_GPR(NUM_GPR), .NUM_VEC(NUM_VEC), .DATA_W(DATA_W),
                 .IDX_W(IDX_W)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wb_commit),
        .wsel    (wb_idx),
        .wdata   (wb_data),
        .ra_sel  (rd_a_idx),
        .rb_sel  (rd_b_idx),
        .ra_data (rd_a_data),
        .rb_data (rd_b_data)
    );

    // Error pulse register: one cycle after any illegal access.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= issue_err || wb_err;
    end

    assign err = err_q;
endmodule

// File: rtl/sb_checker.sv
`timescale 1ns/1ps
// sb_checker: temporal properties of reg_scoreboard, attached through bind.
module sb_checker #(
    parameter int NREG  = 32,
    parameter int IDX_W = 6
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_a_valid,
    input logic [IDX_W-1:0]      rd_a_idx,
    input logic                  iss_valid,
    input logic [1:0]            iss_kind,
    input logic [IDX_W-1:0]      iss_dst,
    input logic                  stall,
    input logic signed [IDX_W:0] rsv_tag,
    input logic                  wb_valid,
    input logic signed [IDX_W:0] wb_tag,
    input logic                  err
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !err);

    // R2
    reserved_read_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_tag > 0) |=> (!(rd_a_valid && rd_a_idx == $past(rsv_tag[IDX_W-1:0])) || stall));

    // R3
    reserve_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_tag >= 0) |-> (iss_valid && !stall && iss_kind == 2'd0));

    // R4
    no_dest_kinds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_kind != 2'd0) |-> (rsv_tag == -1));

    // R5
    zero_never_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_dst == '0) |-> (rsv_tag == -1));

    // R10
    bad_wb_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_tag[IDX_W] && wb_tag[IDX_W-1:0] >= IDX_W'(NREG)) |=> err);
endmodule

bind reg_scoreboard sb_checker #(.NREG(NUM_GPR + NUM_VEC), .IDX_W(IDX_W)) u_sb_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_valid (rd_a_valid),
    .rd_a_idx   (rd_a_idx),
    .iss_valid  (iss_valid),
    .iss_kind   (iss_kind),
    .iss_dst    (iss_dst),
    .stall      (stall),
    .rsv_tag    (rsv_tag),
    .wb_valid   (wb_valid),
    .wb_tag     (wb_tag),
    .err        (err)
);

// File: tb/reg_scoreboard_bench.sv
`timescale 1ns/1ps
module reg_scoreboard_bench;
    localparam int NUM_GPR = 16;
    localparam int NUM_VEC = 16;
    localparam int NREG    = NUM_GPR + NUM_VEC;
    localparam int DATA_W  = 32;
    localparam int IDX_W   = 6;
    localparam int CNT_MAX = 3;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  rd_a_valid = 1'b0, rd_b_valid = 1'b0;
    logic [IDX_W-1:0]      rd_a_idx = '0, rd_b_idx = '0;
    logic [DATA_W-1:0]     rd_a_data, rd_b_data;
    logic                  iss_valid = 1'b0;
    logic [1:0]            iss_kind = '0;
    logic [IDX_W-1:0]      iss_dst = '0;
    logic                  stall;
    logic signed [IDX_W:0] rsv_tag;
    logic                  wb_valid = 1'b0;
    logic signed [IDX_W:0] wb_tag = '1;
    logic [DATA_W-1:0]     wb_data = '0;
    logic                  err;

    reg_scoreboard #(.NUM_GPR(NUM_GPR), .NUM_VEC(NUM_VEC), .DATA_W(DATA_W),
                     .IDX_W(IDX_W), .CNT_W(2)) u_reg_scoreboard (
        .clk(clk), .rst_n(rst_n),
        .rd_a_valid(rd_a_valid), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_valid(rd_b_valid), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dst(iss_dst),
        .stall(stall), .rsv_tag(rsv_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data), .err(err)
    );

    always #5 clk = ~clk;

    int          checks = 0;
    int          fails  = 0;
    int          cnt_m [NREG];
    logic [31:0] reg_m [NREG];
    bit          exp_err = 1'b0;
    bit          l_stall, l_err;
    int          l_tag;
    logic [31:0] l_a, l_b;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit legal(input int i);
        return i >= 0 && i < NREG;
    endfunction

    function automatic bit busy_m(input int i);
        return legal(i) && cnt_m[i] > 0;
    endfunction

    function automatic logic [31:0] data_m(input int i);
        return legal(i) ? reg_m[i] : 32'd0;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < NREG; i++) begin
            cnt_m[i] = 0;
            reg_m[i] = '0;
        end
        exp_err = 1'b0;
    endtask

    // One cycle: drive, compare outputs with the model, then advance the model.
    task automatic drive(input bit rav, input int ra, input bit rbv, input int rb,
                         input bit iv, input int kind, input int dst,
                         input bit wv, input int wt, input logic [31:0] wd,
                         input string req);
        bit e_stall, e_err_n, wpos, wok;
        int e_tag;
        @(negedge clk);
        rd_a_valid = rav; rd_a_idx = IDX_W'(ra);
        rd_b_valid = rbv; rd_b_idx = IDX_W'(rb);
        iss_valid = iv; iss_kind = 2'(kind); iss_dst = IDX_W'(dst);
        wb_valid = wv; wb_tag = (IDX_W+1)'(wt); wb_data = wd;
        #1;
        e_stall = (rav && busy_m(ra)) || (rbv && busy_m(rb))
               || (iv && kind == 0 && dst != 0 && legal(dst) && cnt_m[dst] == CNT_MAX);
        e_tag = (iv && !e_stall && kind == 0 && dst != 0 && legal(dst)) ? dst : -1;
        l_stall = stall; l_tag = int'(rsv_tag); l_a = rd_a_data; l_b = rd_b_data; l_err = err;
        chk(req, "stall", stall, e_stall);
        chk(req, "rsv_tag", int'(rsv_tag), e_tag);
        chk(req, "rd_a_data", rd_a_data, data_m(ra));
        chk(req, "rd_b_data", rd_b_data, data_m(rb));
        chk(req, "err", err, exp_err);
        wpos = wv && wt > 0;
        wok  = wpos && busy_m(wt);
        e_err_n = (rav && !legal(ra)) || (rbv && !legal(rb))
               || (iv && kind == 0 && !legal(dst)) || (wpos && !wok);
        @(posedge clk);
        if (wok) begin
            cnt_m[wt]--;
            reg_m[wt] = wd;
        end
        if (e_tag > 0) cnt_m[e_tag]++;
        exp_err = e_err_n;
    endtask

    task automatic idle(input string req);
        drive(0, 0, 0, 0, 0, 0, 0, 0, -1, 32'd0, req);
    endtask

    task automatic reserve(input int dst, input string req);
        drive(0, 0, 0, 0, 1, 0, dst, 0, -1, 32'd0, req);
    endtask

    task automatic release_wb(input int t, input logic [31:0] d, input string req);
        drive(0, 0, 0, 0, 0, 0, 0, 1, t, d, req);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        model_clear();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        drive(1, 5, 1, 20, 0, 0, 0, 0, -1, 32'd0, "R1");
        chk("R1", "stall after reset", l_stall, 0);
        chk("R1", "gpr5 after reset", l_a, 0);
        chk("R1", "vec4 after reset", l_b, 0);

        // R3: plain reservation
        reserve(5, "R3");
        chk("R3", "tag for r5", l_tag, 5);
        // R2: read of reserved register stalls; R3: stalled issue reserves nothing
        drive(1, 5, 0, 0, 1, 0, 7, 0, -1, 32'd0, "R2");
        chk("R2", "stall on busy source", l_stall, 1);
        chk("R3", "no reserve while stalled", l_tag, -1);
        drive(1, 6, 1, 7, 0, 0, 0, 0, -1, 32'd0, "R2");
        chk("R2", "free sources no stall", l_stall, 0);

        // R4: compare and store reserve nothing
        drive(1, 1, 1, 2, 1, 1, 9, 0, -1, 32'd0, "R4");
        chk("R4", "compare tag", l_tag, -1);
        drive(1, 3, 1, 4, 1, 2, 9, 0, -1, 32'd0, "R4");
        chk("R4", "store tag", l_tag, -1);
        drive(1, 9, 0, 0, 1, 3, 9, 0, -1, 32'd0, "R4");
        chk("R4", "r9 not busy", l_stall, 0);

        // R5: register zero and non-positive tags
        reserve(0, "R5");
        chk("R5", "dst0 tag", l_tag, -1);
        release_wb(0, 32'hFF, "R5");
        drive(1, 0, 0, 0, 0, 0, 0, 0, -1, 32'd0, "R5");
        chk("R5", "r0 stays zero", l_a, 0);
        chk("R5", "tag0 no error", l_err, 0);

        // R8: two writers on r5
        reserve(5, "R8");
        release_wb(5, 32'hAA, "R8");
        drive(1, 5, 0, 0, 0, 0, 0, 0, -1, 32'd0, "R8");
        chk("R8", "still busy after one release", l_stall, 1);
        release_wb(5, 32'hBB, "R6");
        drive(1, 5, 0, 0, 0, 0, 0, 1, -1, 32'h77, "R6");
        chk("R6", "r5 free", l_stall, 0);
        chk("R6", "r5 committed", l_a, 32'hBB);
        drive(1, 5, 0, 0, 0, 0, 0, 0, -1, 32'd0, "R6");
        chk("R6", "tag -1 no commit", l_a, 32'hBB);
        chk("R6", "tag -1 no error", l_err, 0);

        // R7: vector bank mapping
        reserve(20, "R7");
        release_wb(20, 32'h1234, "R7");
        reserve(16, "R7");
        release_wb(16, 32'h55, "R7");
        drive(1, 20, 1, 4, 0, 0, 0, 0, -1, 32'd0, "R7");
        chk("R7", "vec4 value", l_a, 32'h1234);
        chk("R7", "gpr4 separate", l_b, 0);
        drive(1, 16, 1, 0, 0, 0, 0, 0, -1, 32'd0, "R7");
        chk("R7", "vec0 value", l_a, 32'h55);
        chk("R7", "gpr0 separate", l_b, 0);

        // R9: reserve and release of r12 in the same cycle
        reserve(12, "R9");
        drive(0, 0, 0, 0, 1, 0, 12, 1, 12, 32'd1, "R9");
        chk("R9", "same-cycle reserve granted", l_tag, 12);
        drive(1, 12, 0, 0, 0, 0, 0, 0, -1, 32'd0, "R9");
        chk("R9", "count unchanged, still busy", l_stall, 1);
        release_wb(12, 32'd2, "R9");
        drive(1, 12, 0, 0, 0, 0, 0, 0, -1, 32'd0, "R9");
        chk("R9", "r12 free", l_stall, 0);
        chk("R9", "r12 value", l_a, 2);

        // R11: saturation on r3
        reserve(3, "R11");
        reserve(3, "R11");
        reserve(3, "R11");
        drive(0, 0, 0, 0, 1, 0, 3, 1, 3, 32'd9, "R11");
        chk("R11", "full stalls", l_stall, 1);
        chk("R11", "full no tag", l_tag, -1);
        release_wb(3, 32'd10, "R11");
        release_wb(3, 32'd11, "R11");

        // R10: error sources
        drive(1, 40, 0, 0, 0, 0, 0, 0, -1, 32'd0, "R10");
        idle("R10");
        chk("R10", "illegal source", l_err, 1);
        release_wb(3, 32'd1, "R10");
        release_wb(50, 32'd1, "R10");
        chk("R10", "release of free reg", l_err, 1);
        reserve(45, "R10");
        chk("R10", "illegal dst no tag", l_tag, -1);
        chk("R10", "illegal wb tag", l_err, 1);
        idle("R10");
        chk("R10", "illegal dst", l_err, 1);
        drive(1, 3, 0, 0, 0, 0, 0, 0, -1, 32'd0, "R10");
        chk("R10", "error clears", l_err, 0);
        chk("R10", "bad release wrote nothing", l_a, 32'd11);

        // Random mix of reads, issues and releases against the model (R2 R3 R6 R9)
        for (int n = 0; n < 3000; n++) begin
            int ra, rb, dst, wt, kind;
            ra   = ($urandom % 32 == 0) ? 32 + int'($urandom % 8) : int'($urandom % 32);
            rb   = int'($urandom % 32);
            dst  = ($urandom % 40 == 0) ? 33 : int'($urandom % 32);
            kind = ($urandom % 4 == 0) ? int'($urandom % 4) : 0;
            wt   = int'($urandom % 34) - 1;
            drive($urandom % 2 == 1, ra, $urandom % 2 == 1, rb, $urandom % 2 == 1, kind, dst,
                  $urandom % 3 != 0, wt, $urandom, "R2 R3 R6 R9 random");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule